// File: doc/BRIEF.md
# In-Stream Process-Data Window Exchanger

This block sits in the byte path of a slave node on a daisy-chained Ethernet ring. Only the master starts frames; each node alters a frame only as it flows past. The block forwards every byte with a fixed delay of one clock cycle. Inside the frame it counts byte positions, and when a position falls inside the locally configured window it does two things at once. It takes the incoming byte into a receive buffer, and it sends out a byte from a local transmit buffer in that byte's place. All other bytes go through unchanged, so the frame is never held back for a store-and-forward pass.

The window is set by a start offset and two lengths: one for received bytes and one for sent bytes. The window reaches as far as the longer of the two lengths. Received bytes are first kept in a shadow store. They reach the readable buffer only when the frame ends properly. A frame cut short by a new start keeps the previously committed contents. A one-cycle event marks each commit that took in data.

Top module: `frame_pd_exchanger`

## Requirements
- R1: Outputs `out_valid`, `out_sof` and `out_eof` equal `in_valid`, `in_valid&in_sof` and `in_valid&in_eof` of the previous cycle. The byte accepted in cycle n appears on `out_data` in cycle n+1.
- R2: The byte that carries `in_sof` has frame index 0. Later valid bytes count up by one, with cycles where `in_valid` is low skipped. The payload position is the index minus `HDR_LEN` (default 2), and the window starts at payload position `cfg_start`.
- R3: These bytes leave with their value unchanged: bytes outside the window, bytes outside any frame, and window bytes at offsets that are at or beyond both lengths.
- R4: The byte at window offset k, where k < `cfg_tx_len` and k < `DEPTH`, leaves as transmit entry k.
- R5: The byte at window offset k, where k < `cfg_rx_len` and k < `DEPTH`, is captured for receive entry k.
- R6: Captured bytes become readable on `rx_rdata` (combinational read at `rx_addr`) in the cycle after the byte carrying `in_eof`. A window clipped by the frame end updates only the entries it reached. The other entries keep their values.
- R7: If a frame is cut short by a new `in_sof` before its `in_eof`, its captured bytes are dropped and the receive buffer does not change.
- R8: `rx_evt` is high for one cycle, in the cycle after a properly ended frame that captured at least one byte. Otherwise it stays low.
- R9: After reset, all outputs are low and every receive and transmit entry reads 0.
- R10: Lengths larger than `DEPTH` act as `DEPTH`. Window offsets at `DEPTH` or beyond pass through unchanged.
- R11: A write with `tx_we` high sets transmit entry `tx_addr` to `tx_wdata`. The new value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_sof | input | 1 | Start-of-frame marker of the incoming byte |
| in_valid | input | 1 | Incoming byte valid |
| in_eof | input | 1 | End-of-frame marker of the incoming byte |
| in_data | input | 8 | Incoming byte |
| out_sof | output | 1 | Start-of-frame marker, delayed |
| out_valid | output | 1 | Outgoing byte valid |
| out_eof | output | 1 | End-of-frame marker, delayed |
| out_data | output | 8 | Outgoing byte |
| cfg_start | input | OFS_W | Window start, payload position |
| cfg_rx_len | input | LEN_W | Number of bytes to capture |
| cfg_tx_len | input | LEN_W | Number of bytes to insert |
| tx_we | input | 1 | Transmit entry write enable |
| tx_addr | input | $clog2(DEPTH) | Transmit entry index |
| tx_wdata | input | 8 | Transmit entry data |
| rx_addr | input | $clog2(DEPTH) | Receive entry read index |
| rx_rdata | output | 8 | Committed receive entry |
| rx_evt | output | 1 | Commit event pulse |

## Verification
Frames are sent with several window shapes. Equal lengths at offset 0 separate insertion from capture. A shifted window with a longer transmit length, plus input gaps, shows whether positions are counted per valid byte and not per cycle. A longer receive length shows which window bytes are captured but not replaced. A window that runs past the frame end, a truncated frame, single-byte frames and oversize lengths show that commits are kept apart: clipped entries keep old data, aborted frames leave no trace, and entries beyond the buffer pass through. A behavioural model predicts every output and one receive entry on every cycle.

// File: rtl/frame_pd_exchanger.sv
module frame_pd_exchanger #(
  parameter int HDR_LEN = 2,
  parameter int DEPTH   = 16,
  parameter int OFS_W   = 12,
  parameter int LEN_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_sof,
  input  logic                     in_valid,
  input  logic                     in_eof,
  input  logic [7:0]               in_data,
  output logic                     out_sof,
  output logic                     out_valid,
  output logic                     out_eof,
  output logic [7:0]               out_data,
  input  logic [OFS_W-1:0]         cfg_start,
  input  logic [LEN_W-1:0]         cfg_rx_len,
  input  logic [LEN_W-1:0]         cfg_tx_len,
  input  logic                     tx_we,
  input  logic [$clog2(DEPTH)-1:0] tx_addr,
  input  logic [7:0]               tx_wdata,
  input  logic [$clog2(DEPTH)-1:0] rx_addr,
  output logic [7:0]               rx_rdata,
  output logic                     rx_evt
);
  localparam int AW    = $clog2(DEPTH);
  localparam int IDX_W = OFS_W + LEN_W + 1;

  logic             in_frame;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_buf [DEPTH];
  logic [7:0]       rx_buf [DEPTH];
  logic [7:0]       shadow [DEPTH];
  logic [DEPTH-1:0] mask, hit_v, keep_v;

  wire              active = in_valid && (in_sof || in_frame);
  wire              commit = active && in_eof;
  wire [IDX_W-1:0]  idx    = in_sof ? '0 : idx_q;
  wire [IDX_W-1:0]  base   = IDX_W'(HDR_LEN) + IDX_W'(cfg_start);
  wire              past_s = idx >= base;
  wire [IDX_W-1:0]  rel    = idx - base;
  wire              in_buf = rel < IDX_W'(DEPTH);
  wire              tx_hit = active && past_s && in_buf && rel < IDX_W'(cfg_tx_len);
  wire              rx_hit = active && past_s && in_buf && rel < IDX_W'(cfg_rx_len);
  wire [AW-1:0]     slot   = rel[AW-1:0];

  assign rx_rdata = rx_buf[rx_addr];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) hit_v[i] = rx_hit && (slot == AW'(i));
    keep_v = in_sof ? '0 : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idx_q    <= '0;
    end else if (active) begin
      in_frame <= !in_eof;
      idx_q    <= (idx == '1) ? idx : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sof   <= 1'b0;
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      rx_evt    <= 1'b0;
    end else begin
      out_sof   <= in_valid && in_sof;
      out_valid <= in_valid;
      out_eof   <= in_valid && in_eof;
      out_data  <= tx_hit ? tx_buf[slot] : in_data;
      rx_evt    <= commit && |(keep_v | hit_v);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tx_buf[i] <= '0;
        rx_buf[i] <= '0;
        shadow[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tx_we && tx_addr == AW'(i)) tx_buf[i] <= tx_wdata;
        if (hit_v[i]) shadow[i] <= in_data;
        if (commit) begin
          if (hit_v[i])       rx_buf[i] <= in_data;
          else if (keep_v[i]) rx_buf[i] <= shadow[i];
        end
      end
      if (commit)                 mask <= '0;
      else if (active && in_sof)  mask <= hit_v;
      else                        mask <= mask | hit_v;
    end
  end

  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !in_frame) |=> out_data == $past(in_data));
  // R8
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> $past(in_valid && in_eof));

  for (genvar g = 0; g < DEPTH; g++) begin : g_hold
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> $stable(rx_buf[g]));
  end
endmodule

// File: tb/frame_pd_exchanger_tb.sv
module frame_pd_exchanger_tb_top;
  localparam int HDR = 2;
  localparam int D   = 16;

  logic clk = 0, rst_n = 0;
  logic in_sof = 0, in_valid = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic out_sof, out_valid, out_eof, rx_evt;
  logic [7:0] out_data, rx_rdata;
  logic [11:0] cfg_start = 0;
  logic [7:0] cfg_rx_len = 0, cfg_tx_len = 0;
  logic tx_we = 0;
  logic [3:0] tx_addr = 0, rx_addr = 0;
  logic [7:0] tx_wdata = 0;

  frame_pd_exchanger #(.HDR_LEN(HDR), .DEPTH(D), .OFS_W(12), .LEN_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_valid(in_valid), .in_eof(in_eof),
    .in_data(in_data), .out_sof(out_sof), .out_valid(out_valid), .out_eof(out_eof),
    .out_data(out_data), .cfg_start(cfg_start), .cfg_rx_len(cfg_rx_len),
    .cfg_tx_len(cfg_tx_len), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .rx_addr(rx_addr), .rx_rdata(rx_rdata), .rx_evt(rx_evt));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_idx = 0;
  bit m_in = 0;
  logic [7:0] txm [D];
  logic [7:0] rxm [D];
  logic [7:0] pend [D];
  bit pendv [D];
  int ptr = 0;
  string cur_tag = "R9";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit v, input bit e, input logic [7:0] d);
    int idx, k;
    bit rep, ev;
    logic [7:0] ed;
    in_sof = s; in_valid = v; in_eof = e; in_data = d;
    @(posedge clk);
    rep = 0; ev = 0; ed = d;
    if (v && (s || m_in)) begin
      idx = s ? 0 : m_idx;
      if (s) for (int i = 0; i < D; i++) pendv[i] = 0;
      k = idx - HDR - int'(cfg_start);
      if (k >= 0) begin
        if (k < int'(cfg_tx_len) && k < D) begin rep = 1; ed = txm[k]; end
        if (k < int'(cfg_rx_len) && k < D) begin pend[k] = d; pendv[k] = 1; end
      end
      if (e) begin
        for (int i = 0; i < D; i++) if (pendv[i]) begin rxm[i] = pend[i]; ev = 1; pendv[i] = 0; end
        m_in = 0;
      end else begin
        m_in = 1; m_idx = idx + 1;
      end
    end
    if (tx_we) txm[tx_addr] = tx_wdata;
    @(negedge clk);
    rx_addr = 4'(ptr);
    #1;
    chk("R1", out_valid, v);
    chk("R1", out_sof, v & s);
    chk("R1", out_eof, v & e);
    if (v) chk(rep ? "R4" : "R3", out_data, ed);
    chk("R8", rx_evt, ev);
    chk(cur_tag, rx_rdata, rxm[ptr]);
    ptr = (ptr + 1) % D;
    tx_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
  endtask

  task automatic frame(input int n, input logic [7:0] b, input int gap, input bit fin);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i % gap == 1) step(0, 0, 0, 8'h5A);
      step(i == 0, 1, fin && i == n - 1, b + 8'(i));
    end
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin txm[i] = 0; rxm[i] = 0; pendv[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_tag = "R9";
    #1;
    chk("R9", out_valid, 0); chk("R9", out_sof, 0); chk("R9", out_eof, 0);
    chk("R9", out_data, 0); chk("R9", rx_evt, 0);
    idle(D);
    cfg_start = 0; cfg_tx_len = 2; cfg_rx_len = 0;
    frame(6, 8'h30, 0, 1);   // R9 transmit entries read 0
    idle(2);

    cur_tag = "R11";
    for (int i = 0; i < D; i++) begin
      tx_we = 1; tx_addr = 4'(i); tx_wdata = 8'hA0 + 8'(i);
      step(0, 0, 0, 0);
    end

    cur_tag = "R5";
    cfg_start = 0; cfg_rx_len = 4; cfg_tx_len = 4;
    frame(10, 8'h10, 0, 1);
    idle(D);

    cur_tag = "R2";
    cfg_start = 3; cfg_rx_len = 2; cfg_tx_len = 5;
    frame(14, 8'h40, 3, 1);
    idle(D);

    cur_tag = "R5";
    cfg_start = 1; cfg_rx_len = 6; cfg_tx_len = 1;
    frame(12, 8'h60, 0, 1);
    step(0, 1, 0, 8'h77);    // R3 byte outside any frame
    idle(D);

    cur_tag = "R6";
    cfg_start = 5; cfg_rx_len = 8; cfg_tx_len = 8;
    frame(9, 8'h80, 0, 1);
    idle(D);

    cur_tag = "R7";
    cfg_start = 0; cfg_rx_len = 4; cfg_tx_len = 0;
    frame(5, 8'hE0, 0, 0);
    idle(4);
    cfg_start = 50;
    frame(6, 8'hC0, 0, 1);
    idle(D);

    cur_tag = "R11";
    tx_we = 1; tx_addr = 0; tx_wdata = 8'h3C;
    step(0, 0, 0, 0);
    cfg_start = 0; cfg_tx_len = 1; cfg_rx_len = 1;
    frame(4, 8'h20, 0, 1);
    idle(2);

    cur_tag = "R10";
    cfg_start = 0; cfg_rx_len = 20; cfg_tx_len = 20;
    frame(24, 8'h90, 0, 1);
    idle(D);

    cur_tag = "R8";
    step(1, 1, 1, 8'h11);
    step(1, 1, 1, 8'h12);
    cfg_start = 0; cfg_rx_len = 3; cfg_tx_len = 2;
    frame(5, 8'h01, 0, 1);
    frame(5, 8'hF0, 0, 1);
    idle(D);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule